// File: doc/BRIEF.md
# Host I/O Mailbox Channel

This block is a byte-wide mailbox that joins a host I/O bus to a local controller. The host reaches it at two I/O addresses: a data port at a parameterised base and a command port four above it. A host write to either port latches the byte into an inbound register, raises the inbound-full flag and records which port was used, so the local firmware can tell a command from its operands. The local side drains the inbound byte, posts a reply byte into the outbound register, and keeps a busy flag and two event-pending flags in the status byte that the host polls.

Two level interrupt requests go to the local controller. One asks for service while an inbound byte waits. The other asks for a new reply while the outbound register is empty. Each has its own enable bit. The local side reaches the block through a small register window selected by a three-bit address.

Top module: `mbx_channel`

## Requirements
- R1: After reset the status byte, the control bits, the inbound byte and the outbound byte are all zero, and both interrupt outputs are low.
- R2: A host write to the data port (BASE) or to the command port (BASE+4) loads the byte into the inbound register and sets IBF (status bit 1). Bit 3 of the status byte becomes 1 for the command port and 0 for the data port.
- R3: A host write while IBF is already set replaces the inbound byte and keeps IBF set.
- R4: A local read at local address 0 returns the inbound byte, and the next cycle shows IBF cleared. The command/data flag is left unchanged.
- R5: A local write at local address 1 loads the outbound byte and sets OBF (status bit 0). A host read of the data port returns the outbound byte, and the next cycle shows OBF cleared.
- R6: A host read of the command port returns the status byte without changing any state. Layout: bit0 OBF, bit1 IBF, bit2 busy, bit3 last write was command, bit5 SCI pending, bit6 SMI pending, bits 4 and 7 read 0.
- R7: A local write at address 2 sets, and at address 3 clears, the status bits among busy (bit2), SCI (bit5) and SMI (bit6) whose positions are 1 in the written byte. Other bits of the byte are ignored. A local read at address 2 returns the status byte.
- R8: Local address 4 holds the control bits: bit0 enables the input-full interrupt, bit1 enables the output-empty interrupt. They read back at bits 1:0 with zeros above. `irq_in_full` is high while IBF=1 and bit0=1. `irq_out_empty` is high while OBF=0 and bit1=1.
- R9: Host writes to any other address change nothing, and host reads of any other address return 0.
- R10: When a host write and a local address-0 read fall in the same cycle, the read returns the old byte, and afterwards IBF is set and the new byte is held.
- R11: When a local address-1 write and a host data-port read fall in the same cycle, the host gets the old outbound byte, and afterwards OBF is set and the new byte is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Host I/O address |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, valid in the strobe cycle |
| loc_addr | input | 3 | Local register select |
| loc_wr | input | 1 | Local write strobe |
| loc_rd | input | 1 | Local read strobe |
| loc_wdata | input | 8 | Local write byte |
| loc_rdata | output | 8 | Local read byte, valid in the strobe cycle |
| irq_in_full | output | 1 | Input-full interrupt request (level) |
| irq_out_empty | output | 1 | Output-empty interrupt request (level) |

## Verification
Every flag in this block is visible through a status read on either side, so a wrong flag shows up in the first status read that follows, one cycle after the access that caused it. A lost or stale byte shows up only when that byte is drained, so the random stimulus keeps reads frequent and mixes in same-cycle collisions on both buffers. An interrupt driven from the wrong state differs from the bench model at once, because the bench compares both request lines on every cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int unsigned BYTE_W = 8;

    // local register window
    localparam logic [2:0] LSEL_DIN  = 3'd0;
    localparam logic [2:0] LSEL_DOUT = 3'd1;
    localparam logic [2:0] LSEL_SSET = 3'd2;
    localparam logic [2:0] LSEL_SCLR = 3'd3;
    localparam logic [2:0] LSEL_CTRL = 3'd4;

    // status bit positions
    localparam int unsigned ST_OBF  = 0;
    localparam int unsigned ST_IBF  = 1;
    localparam int unsigned ST_BUSY = 2;
    localparam int unsigned ST_CMD  = 3;
    localparam int unsigned ST_SCI  = 5;
    localparam int unsigned ST_SMI  = 6;

    // control bit positions
    localparam int unsigned CT_IFIE = 0;
    localparam int unsigned CT_OEIE = 1;

    typedef struct packed {
        logic [BYTE_W-1:0] in_byte;
        logic [BYTE_W-1:0] out_byte;
        logic              ibf;
        logic              obf;
        logic              cmd;
        logic              busy;
        logic              sci;
        logic              smi;
        logic [1:0]        ctrl;
    } mbx_state_t;

    typedef struct packed {
        logic wr_data;
        logic wr_cmd;
        logic rd_data;
        logic rd_cmd;
    } host_hit_t;

    typedef struct packed {
        logic din_rd;
        logic dout_wr;
        logic sset_wr;
        logic sclr_wr;
        logic ctrl_wr;
    } loc_hit_t;

    function automatic logic [BYTE_W-1:0] pack_status(input mbx_state_t s);
        logic [BYTE_W-1:0] b;
        b          = '0;
        b[ST_OBF]  = s.obf;
        b[ST_IBF]  = s.ibf;
        b[ST_BUSY] = s.busy;
        b[ST_CMD]  = s.cmd;
        b[ST_SCI]  = s.sci;
        b[ST_SMI]  = s.smi;
        return b;
    endfunction

endpackage

// File: rtl/mbx_host_dec.sv
module mbx_host_dec
    import mbx_pkg::*;
#(
    parameter int unsigned      ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] BASE   = 16'h0200,
    parameter int unsigned      CMD_OFF = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output host_hit_t         hit
);
    localparam logic [ADDR_W-1:0] CMD_ADDR = BASE + ADDR_W'(CMD_OFF);

    logic at_data;
    logic at_cmd;

    always_comb begin
        at_data     = (addr == BASE);
        at_cmd      = (addr == CMD_ADDR);
        hit.wr_data = wr && at_data;
        hit.wr_cmd  = wr && at_cmd;
        hit.rd_data = rd && at_data;
        hit.rd_cmd  = rd && at_cmd;
    end
endmodule

// File: rtl/mbx_local_dec.sv
module mbx_local_dec
    import mbx_pkg::*;
(
    input  logic [2:0] addr,
    input  logic       wr,
    input  logic       rd,
    output loc_hit_t   hit
);
    always_comb begin
        hit.din_rd  = rd && (addr == LSEL_DIN);
        hit.dout_wr = wr && (addr == LSEL_DOUT);
        hit.sset_wr = wr && (addr == LSEL_SSET);
        hit.sclr_wr = wr && (addr == LSEL_SCLR);
        hit.ctrl_wr = wr && (addr == LSEL_CTRL);
    end
endmodule

// File: rtl/mbx_core.sv
module mbx_core
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  host_hit_t         hh,
    input  loc_hit_t          lh,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic [BYTE_W-1:0] loc_wdata,
    output mbx_state_t        st
);
    mbx_state_t st_d;
    mbx_state_t st_q;

    logic host_fill;
    logic [2:0] flag_mask;

    always_comb begin
        st_d      = st_q;
        host_fill = hh.wr_data || hh.wr_cmd;
        flag_mask = {loc_wdata[ST_SMI], loc_wdata[ST_SCI], loc_wdata[ST_BUSY]};

        // inbound path: a host fill wins over a same-cycle drain
        if (host_fill) begin
            st_d.in_byte = host_wdata;
            st_d.ibf     = 1'b1;
            st_d.cmd     = hh.wr_cmd;
        end else if (lh.din_rd) begin
            st_d.ibf = 1'b0;
        end

        // outbound path: a local post wins over a same-cycle host drain
        if (lh.dout_wr) begin
            st_d.out_byte = loc_wdata;
            st_d.obf      = 1'b1;
        end else if (hh.rd_data) begin
            st_d.obf = 1'b0;
        end

        // local flags
        if (lh.sset_wr) begin
            st_d.busy = st_q.busy | flag_mask[0];
            st_d.sci  = st_q.sci  | flag_mask[1];
            st_d.smi  = st_q.smi  | flag_mask[2];
        end
        if (lh.sclr_wr) begin
            st_d.busy = st_q.busy & ~flag_mask[0];
            st_d.sci  = st_q.sci  & ~flag_mask[1];
            st_d.smi  = st_q.smi  & ~flag_mask[2];
        end

        if (lh.ctrl_wr) begin
            st_d.ctrl = loc_wdata[1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
    import mbx_pkg::*;
(
    input  mbx_state_t st,
    output logic       irq_in_full,
    output logic       irq_out_empty
);
    always_comb begin
        irq_in_full   = st.ibf  && st.ctrl[CT_IFIE];
        irq_out_empty = !st.obf && st.ctrl[CT_OEIE];
    end
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
    import mbx_pkg::*;
#(
    parameter int unsigned       ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] BASE    = 16'h0200,
    parameter int unsigned       CMD_OFF = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic [2:0]        loc_addr,
    input  logic              loc_wr,
    input  logic              loc_rd,
    input  logic [7:0]        loc_wdata,
    output logic [7:0]        loc_rdata,
    output logic              irq_in_full,
    output logic              irq_out_empty
);
    host_hit_t   hh;
    loc_hit_t    lh;
    mbx_state_t  st;
    logic [7:0]  stat_byte;
    logic [7:0]  in_byte;

    mbx_host_dec #(
        .ADDR_W (ADDR_W),
        .BASE   (BASE),
        .CMD_OFF(CMD_OFF)
    ) u_hdec (
        .addr(host_addr),
        .wr  (host_wr),
        .rd  (host_rd),
        .hit (hh)
    );

    mbx_local_dec u_ldec (
        .addr(loc_addr),
        .wr  (loc_wr),
        .rd  (loc_rd),
        .hit (lh)
    );

    mbx_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .hh        (hh),
        .lh        (lh),
        .host_wdata(host_wdata),
        .loc_wdata (loc_wdata),
        .st        (st)
    );

    mbx_irq u_irq (
        .st           (st),
        .irq_in_full  (irq_in_full),
        .irq_out_empty(irq_out_empty)
    );

    always_comb begin
        stat_byte = pack_status(st);
        in_byte   = st.in_byte;

        if (hh.rd_data) begin
            host_rdata = st.out_byte;
        end else if (hh.rd_cmd) begin
            host_rdata = stat_byte;
        end else begin
            host_rdata = '0;
        end

        loc_rdata = '0;
        if (loc_rd) begin
            unique case (loc_addr)
                LSEL_DIN:  loc_rdata = st.in_byte;
                LSEL_SSET: loc_rdata = stat_byte;
                LSEL_CTRL: loc_rdata = {6'b0, st.ctrl};
                default:   loc_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/mbx_channel_chk.sv
module mbx_channel_chk #(
    parameter int unsigned       ADDR_W  = 16,
    parameter logic [ADDR_W-1:0] BASE    = 16'h0200,
    parameter int unsigned       CMD_OFF = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_wr,
    input logic              host_rd,
    input logic [7:0]        host_wdata,
    input logic [2:0]        loc_addr,
    input logic              loc_wr,
    input logic              loc_rd,
    input logic              irq_in_full,
    input logic              irq_out_empty,
    input logic [7:0]        stat_byte,
    input logic [7:0]        in_byte
);
    localparam logic [ADDR_W-1:0] CMD_ADDR = BASE + ADDR_W'(CMD_OFF);

    logic hit_any;
    logic drain_in;
    logic post_out;
    assign hit_any  = (host_addr == BASE) || (host_addr == CMD_ADDR);
    assign drain_in = loc_rd && (loc_addr == 3'd0);
    assign post_out = loc_wr && (loc_addr == 3'd1);

    p_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && hit_any) |=> (stat_byte[1] && in_byte == $past(host_wdata)));

    p_cmdflag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == CMD_ADDR) |=> stat_byte[3]);

    p_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (drain_in && !(host_wr && hit_any)) |=> !stat_byte[1]);

    p_post_r5: assert property (@(posedge clk) disable iff (!rst_n)
        post_out |=> stat_byte[0]);

    p_hostdrain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == BASE && !post_out) |=> !stat_byte[0]);

    p_rsvd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_byte[4] == 1'b0) && (stat_byte[7] == 1'b0));

    p_irqin_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_in_full |-> stat_byte[1]);

    p_irqout_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out_empty |-> !stat_byte[0]);

    p_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !hit_any && !drain_in) |=> ($stable(in_byte) && $stable(stat_byte[1])));
endmodule

bind mbx_channel mbx_channel_chk #(
    .ADDR_W (ADDR_W),
    .BASE   (BASE),
    .CMD_OFF(CMD_OFF)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_addr    (host_addr),
    .host_wr      (host_wr),
    .host_rd      (host_rd),
    .host_wdata   (host_wdata),
    .loc_addr     (loc_addr),
    .loc_wr       (loc_wr),
    .loc_rd       (loc_rd),
    .irq_in_full  (irq_in_full),
    .irq_out_empty(irq_out_empty),
    .stat_byte    (stat_byte),
    .in_byte      (in_byte)
);

// File: tb/mbx_channel_tb.sv
`timescale 1ns/1ps
module mbx_channel_tb;
    localparam logic [15:0] BASE = 16'h0200;
    localparam logic [15:0] CMDA = 16'h0204;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] host_addr = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [2:0]  loc_addr = '0;
    logic        loc_wr = 1'b0, loc_rd = 1'b0;
    logic [7:0]  loc_wdata = '0;
    logic [7:0]  loc_rdata;
    logic        irq_in_full, irq_out_empty;

    int vectors = 0;
    int fails = 0;

    // bench model
    logic [7:0] m_in = 0, m_out = 0;
    logic m_ibf = 0, m_obf = 0, m_cmd = 0, m_busy = 0, m_sci = 0, m_smi = 0;
    logic [1:0] m_ctrl = 0;

    always #2.5 clk = ~clk;

    mbx_channel #(.ADDR_W(16), .BASE(BASE), .CMD_OFF(4)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .loc_addr(loc_addr), .loc_wr(loc_wr), .loc_rd(loc_rd),
        .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
        .irq_in_full(irq_in_full), .irq_out_empty(irq_out_empty)
    );

    function automatic logic [7:0] exp_status();
        return {1'b0, m_smi, m_sci, 1'b0, m_cmd, m_busy, m_ibf, m_obf};
    endfunction

    function automatic logic [7:0] exp_host_rd(input logic [15:0] a);
        if (a == BASE) return m_out;
        if (a == CMDA) return exp_status();
        return 8'h00;
    endfunction

    function automatic logic [7:0] exp_loc_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_in;
            3'd2: return exp_status();
            3'd4: return {6'b0, m_ctrl};
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // one bus cycle: drive at negedge, check combinational outputs, update model at posedge
    task automatic cyc(input logic hw, input logic hr, input logic [15:0] ha, input logic [7:0] hd,
                       input logic lw, input logic lr, input logic [2:0] la, input logic [7:0] ld,
                       input string tag);
        string t;
        @(negedge clk);
        host_wr = hw; host_rd = hr; host_addr = ha; host_wdata = hd;
        loc_wr = lw; loc_rd = lr; loc_addr = la; loc_wdata = ld;
        #1;
        chk("R8 irq_in_full", {7'b0, irq_in_full}, {7'b0, m_ibf && m_ctrl[0]});
        chk("R8 irq_out_empty", {7'b0, irq_out_empty}, {7'b0, !m_obf && m_ctrl[1]});
        if (hr) begin
            t = (ha == BASE) ? "R5 host data" : (ha == CMDA) ? "R6 host status" : "R9 host miss";
            if (tag != "") t = tag;
            chk(t, host_rdata, exp_host_rd(ha));
        end
        if (lr) begin
            t = (la == 3'd0) ? "R4 local in" : (la == 3'd2) ? "R7 local status" : "R8 local ctrl";
            if (tag != "") t = tag;
            chk(t, loc_rdata, exp_loc_rd(la));
        end
        @(posedge clk);
        if (hw && (ha == BASE || ha == CMDA)) begin
            m_in = hd; m_ibf = 1'b1; m_cmd = (ha == CMDA);
        end else if (lr && la == 3'd0) begin
            m_ibf = 1'b0;
        end
        if (lw && la == 3'd1) begin
            m_out = ld; m_obf = 1'b1;
        end else if (hr && ha == BASE) begin
            m_obf = 1'b0;
        end
        if (lw && la == 3'd2) begin
            m_busy |= ld[2]; m_sci |= ld[5]; m_smi |= ld[6];
        end
        if (lw && la == 3'd3) begin
            m_busy &= ~ld[2]; m_sci &= ~ld[5]; m_smi &= ~ld[6];
        end
        if (lw && la == 3'd4) m_ctrl = ld[1:0];
    endtask

    task automatic idle();
        cyc(0, 0, 16'h0, 8'h0, 0, 0, 3'd0, 8'h0, "");
    endtask

    task automatic stat_chk(input string tag);
        cyc(0, 0, 16'h0, 8'h0, 0, 1, 3'd2, 8'h0, tag);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1a2b3c4d));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        stat_chk("R1 status after reset");
        cyc(0, 0, 16'h0, 8'h0, 0, 1, 3'd4, 8'h0, "R1 ctrl after reset");
        cyc(0, 1, BASE, 8'h0, 0, 1, 3'd0, 8'h0, "R1 bytes after reset");

        // R2: data-port and command-port fills
        cyc(1, 0, BASE, 8'h3c, 0, 0, 3'd0, 8'h0, "");
        stat_chk("R2 data port fill");
        cyc(0, 0, 16'h0, 8'h0, 0, 1, 3'd0, 8'h0, "R4 drain data byte");
        cyc(1, 0, CMDA, 8'h91, 0, 0, 3'd0, 8'h0, "");
        stat_chk("R2 command port fill");
        // R3: overwrite while full
        cyc(1, 0, BASE, 8'h5a, 0, 0, 3'd0, 8'h0, "");
        cyc(0, 0, 16'h0, 8'h0, 0, 1, 3'd0, 8'h0, "R3 overwrite byte");
        stat_chk("R4 IBF clear cmd kept");

        // R8: enables and interrupts
        cyc(0, 0, 16'h0, 8'h0, 1, 0, 3'd4, 8'hff, "");
        cyc(0, 0, 16'h0, 8'h0, 0, 1, 3'd4, 8'h0, "R8 ctrl readback");
        cyc(1, 0, BASE, 8'h11, 0, 0, 3'd0, 8'h0, "");
        idle();
        // R5: post and host drain
        cyc(0, 0, 16'h0, 8'h0, 1, 0, 3'd1, 8'hc7, "");
        cyc(0, 1, BASE, 8'h0, 0, 0, 3'd0, 8'h0, "R5 host read out byte");
        stat_chk("R5 OBF cleared");
        // R6: status read changes nothing
        cyc(0, 1, CMDA, 8'h0, 0, 0, 3'd0, 8'h0, "R6 status via host");
        cyc(0, 1, CMDA, 8'h0, 0, 0, 3'd0, 8'h0, "R6 status unchanged");

        // R7: flag set/clear with ignored bits
        cyc(0, 0, 16'h0, 8'h0, 1, 0, 3'd2, 8'hff, "");
        stat_chk("R7 flags set");
        cyc(0, 0, 16'h0, 8'h0, 1, 0, 3'd3, 8'h24, "");
        stat_chk("R7 busy and sci cleared");
        cyc(0, 0, 16'h0, 8'h0, 1, 0, 3'd3, 8'hff, "");

        // R9: miss addresses
        cyc(1, 0, 16'h0201, 8'hee, 0, 0, 3'd0, 8'h0, "");
        cyc(1, 0, 16'h0066, 8'hdd, 0, 0, 3'd0, 8'h0, "");
        cyc(0, 1, 16'h0203, 8'h0, 0, 1, 3'd0, 8'h0, "R9 miss write and read");

        // R10: fill and drain collide
        cyc(1, 0, BASE, 8'h77, 0, 0, 3'd0, 8'h0, "");
        cyc(1, 0, CMDA, 8'h88, 0, 1, 3'd0, 8'h0, "R10 drain sees old byte");
        stat_chk("R10 IBF stays set");
        cyc(0, 0, 16'h0, 8'h0, 0, 1, 3'd0, 8'h0, "R10 new byte kept");

        // R11: post and host drain collide
        cyc(0, 0, 16'h0, 8'h0, 1, 0, 3'd1, 8'h42, "");
        cyc(0, 1, BASE, 8'h0, 1, 0, 3'd1, 8'h43, "R11 host gets old byte");
        cyc(0, 1, CMDA, 8'h0, 0, 0, 3'd0, 8'h0, "R11 OBF stays set");
        cyc(0, 1, BASE, 8'h0, 0, 0, 3'd0, 8'h0, "R11 new byte kept");

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [15:0] ha;
            logic [2:0]  la;
            logic        lw, lr;
            int          sel;
            sel = $urandom_range(0, 3);
            ha = (sel == 0) ? BASE : (sel == 1) ? CMDA : (sel == 2) ? 16'h0208 : 16'h0066;
            if (($urandom_range(0, 9)) < 6) ha = ($urandom_range(0, 1) != 0) ? BASE : CMDA;
            lw = ($urandom_range(0, 2) == 0);
            lr = !lw && ($urandom_range(0, 1) != 0);
            if (lw) la = 3'($urandom_range(1, 4));
            else begin
                sel = $urandom_range(0, 2);
                la = (sel == 0) ? 3'd0 : (sel == 1) ? 3'd2 : 3'd4;
            end
            cyc($urandom_range(0, 3) == 0, $urandom_range(0, 2) == 0, ha, 8'($urandom),
                lw, lr, la, 8'($urandom), "");
        end

        idle();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule